// File: doc/BRIEF.md
# Opcode-Selected Arithmetic Unit

A combinational arithmetic unit working on two equal-width operands, `a` and `b` (four bits by default, set by the parameter `W`). A three-bit operation code picks one of eight results: either operand passed straight through, the two's complement negation of either operand, the sum read as unsigned or as signed, and the difference taken in either order. The unit drives the chosen `W`-bit result on `x`, along with a single flag `v` that reports overflow for the chosen operation.

Negation inverts every bit and then adds one. Subtraction feeds the inverted subtrahend into an adder with its carry-in set, so no separate subtractor is needed. The datapath has two increment-based negation stages and three ripple adders. Two four-way selectors feed a final two-way choice made on the top code bit. The flag's meaning depends on the code. For an unsigned add it is the carry out. For the signed operations it is two's complement overflow. For a negation it flags the most negative input, which has no positive counterpart. For the pass-through codes it is always 0. Nothing is stored, so `x` and `v` follow the inputs directly.

Top module: `arith_unit`

## Requirements
- R1: With `op` = 0, `x` equals `a` and `v` is 0.
- R2: With `op` = 1, `x` equals `b` and `v` is 0.
- R3: With `op` = 2, `x` equals (2^W − `a`) mod 2^W. `v` is 1 exactly when `a` is the most negative value (only the MSB set, 1000 for W=4).
- R4: With `op` = 3, `x` equals (2^W − `b`) mod 2^W. `v` is 1 exactly when `b` is the most negative value.
- R5: With `op` = 4, `x` equals (`a` + `b`) mod 2^W with both read as unsigned. `v` is 1 exactly when the unsigned sum exceeds 2^W − 1, i.e. when there is a carry out of the MSB.
- R6: With `op` = 5, `x` equals (`a` + `b`) mod 2^W. `v` is 1 exactly when the signed sum of the two's complement operands falls outside [−2^(W−1), 2^(W−1) − 1].
- R7: With `op` = 6, `x` equals (`a` − `b`) mod 2^W. `v` is 1 exactly when the signed difference `a` − `b` falls outside the signed W-bit range.
- R8: With `op` = 7, `x` equals (`b` − `a`) mod 2^W. `v` is 1 exactly when the signed difference `b` − `a` falls outside the signed W-bit range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| op | input | 3 | Operation code, 0 to 7 as listed in R1 to R8 |
| x | output | W | Selected result |
| v | output | 1 | Overflow flag of the selected operation |

## Verification
The unit holds no state. A fault in an internal net, such as a stuck carry, a wrong selector leg or a mis-routed flag, shows at `x` or `v` in the same time step as the input pattern that sensitises it. It shows only under the code that routes that net to the ports. A carry fault, for example, appears only for operand pairs whose carry chain reaches the faulty bit. For this reason every code is driven with every operand pair. Directed vectors cover the flag's edge cases: the most negative value, the carry out of the MSB, and signed sums that cross either range limit.

// File: rtl/arith_unit_pkg.sv
// Package: arith_unit_pkg
// Shared operation codes for the opcode-selected arithmetic unit.
// Assumes a three-bit code; bit 2 separates the pass/negate group from
// the add/subtract group, and bits 1:0 pick within a group.
package arith_unit_pkg;

    typedef enum logic [2:0] {
        OP_PASS_A = 3'd0,
        OP_PASS_B = 3'd1,
        OP_NEG_A  = 3'd2,
        OP_NEG_B  = 3'd3,
        OP_ADD_U  = 3'd4,
        OP_ADD_S  = 3'd5,
        OP_SUB_AB = 3'd6,
        OP_SUB_BA = 3'd7
    } op_e;

endpackage

// File: rtl/au_negate.sv
// Module: au_negate
// Two's complement negation: inverts the operand and adds one with a
// chain of half adders. Returns the carries into and out of the MSB so
// the caller can form the signed overflow flag. Assumes W >= 2.
module au_negate #(
    parameter int W = 4
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [1:0]   carry_hi
);

    logic [W-1:0] inv;
    logic [W:0]   c;

    assign inv  = ~din;
    assign c[0] = 1'b1;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_inc
            // half adder stage of the +1 increment
            assign dout[i] = inv[i] ^ c[i];
            assign c[i+1]  = inv[i] & c[i];
        end
    endgenerate

    assign carry_hi = {c[W], c[W-1]};

endmodule

// File: rtl/au_adder.sv
// Module: au_adder
// Ripple-carry adder built from full adders. Returns the sum and the
// carries out of the MSB (bit 1) and into the MSB (bit 0). Assumes W >= 2.
module au_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x0,
    input  logic [W-1:0] x1,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic [1:0]   carry_hi
);

    logic [W:0] c;

    assign c[0] = cin;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_fa
            // one full adder per bit
            assign sum[i] = x0[i] ^ x1[i] ^ c[i];
            assign c[i+1] = (x0[i] & x1[i]) | (c[i] & (x0[i] ^ x1[i]));
        end
    endgenerate

    assign carry_hi = {c[W], c[W-1]};

endmodule

// File: rtl/au_sel4.sv
// Module: au_sel4
// Per-bit four-way selector of width W. The select code picks one of
// four data words. Purely combinational.
module au_sel4 #(
    parameter int W = 4
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] d0,
    input  logic [W-1:0] d1,
    input  logic [W-1:0] d2,
    input  logic [W-1:0] d3,
    output logic [W-1:0] y
);

    // route the chosen data word to the output
    always_comb begin
        case (sel)
            2'd0:    y = d0;
            2'd1:    y = d1;
            2'd2:    y = d2;
            default: y = d3;
        endcase
    end

endmodule

// File: rtl/arith_unit.sv
// Module: arith_unit
// Opcode-selected arithmetic unit on two W-bit operands. Computes both
// negations, the sum and both differences in parallel. Two four-way
// selectors and a final choice on op[2] then pick the result and its
// overflow flag. Has no clock or reset, so the outputs follow the inputs.
// Assumes W >= 2.
module arith_unit
    import arith_unit_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op,
    output logic [W-1:0] x,
    output logic         v
);

    localparam int          MSB     = W - 1;
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] neg_a, neg_b, sum_ab, dif_ab, dif_ba;
    logic [1:0]   cy_na, cy_nb, cy_sum, cy_ab, cy_ba;
    logic [W-1:0] x_lo, x_hi;
    logic         v_lo, v_hi;
    op_e          opc;

    assign opc = op_e'(op);

    au_negate #(.W(W)) u_neg_a (.din(a), .dout(neg_a), .carry_hi(cy_na));
    au_negate #(.W(W)) u_neg_b (.din(b), .dout(neg_b), .carry_hi(cy_nb));

    au_adder #(.W(W)) u_add (.x0(a), .x1(b),  .cin(1'b0), .sum(sum_ab), .carry_hi(cy_sum));
    au_adder #(.W(W)) u_sab (.x0(a), .x1(~b), .cin(1'b1), .sum(dif_ab), .carry_hi(cy_ab));
    au_adder #(.W(W)) u_sba (.x0(b), .x1(~a), .cin(1'b1), .sum(dif_ba), .carry_hi(cy_ba));

    au_sel4 #(.W(W)) u_xlo (.sel(op[1:0]), .d0(a), .d1(b), .d2(neg_a), .d3(neg_b), .y(x_lo));
    au_sel4 #(.W(W)) u_xhi (.sel(op[1:0]), .d0(sum_ab), .d1(sum_ab), .d2(dif_ab), .d3(dif_ba), .y(x_hi));

    au_sel4 #(.W(1)) u_vlo (.sel(op[1:0]), .d0(1'b0), .d1(1'b0),
                            .d2(^cy_na), .d3(^cy_nb), .y(v_lo));
    au_sel4 #(.W(1)) u_vhi (.sel(op[1:0]), .d0(cy_sum[1]), .d1(^cy_sum),
                            .d2(^cy_ab), .d3(^cy_ba), .y(v_hi));

    // final group choice on the top code bit
    always_comb begin
        x = op[2] ? x_hi : x_lo;
        v = op[2] ? v_hi : v_lo;
    end

    // port-level checks of the operation map
    always_comb begin
        if (opc == OP_PASS_A) begin
            a_r1_pass_a: assert (x == a && !v);
        end
        if (opc == OP_NEG_A) begin
            a_r3_neg_a: assert (x == W'(0) - a && v == (a == MIN_NEG));
        end
        if (opc == OP_ADD_U) begin
            a_r5_add_unsigned: assert ({v, x} == ({1'b0, a} + {1'b0, b}));
        end
        if (opc == OP_ADD_S) begin
            a_r6_add_signed_overflow: assert (x == a + b &&
                v == ((a[MSB] == b[MSB]) && (x[MSB] != a[MSB])));
        end
        if (opc == OP_SUB_AB) begin
            a_r7_sub_ab: assert (x == a - b &&
                v == ((a[MSB] != b[MSB]) && (x[MSB] != a[MSB])));
        end
        if (opc == OP_SUB_BA) begin
            a_r8_sub_ba: assert (x == b - a &&
                v == ((a[MSB] != b[MSB]) && (x[MSB] != b[MSB])));
        end
    end

endmodule

// File: tb/tb_arith_unit.sv
// Bench for arith_unit: a directed vector table walked by one loop, a
// start-of-run check, and then every code with every operand pair against
// an integer reference model.
module tb_arith_unit;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b, x;
    logic [2:0]   op;
    logic         v;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    arith_unit #(.W(W)) dut (.a(a), .b(b), .op(op), .x(x), .v(v));

    // directed vectors: {op, a, b, expected x, expected v}
    localparam int NV = 16;
    localparam logic [15:0] VEC [NV] = '{
        {3'd0, 4'h5, 4'h3, 4'h5, 1'b0},   // R1
        {3'd1, 4'h5, 4'h3, 4'h3, 1'b0},   // R2
        {3'd2, 4'h8, 4'h0, 4'h8, 1'b1},   // R3 most negative
        {3'd2, 4'h1, 4'h0, 4'hF, 1'b0},   // R3
        {3'd3, 4'h0, 4'h0, 4'h0, 1'b0},   // R4 zero
        {3'd3, 4'h0, 4'h8, 4'h8, 1'b1},   // R4 most negative
        {3'd4, 4'hF, 4'h1, 4'h0, 1'b1},   // R5 carry out
        {3'd4, 4'h7, 4'h1, 4'h8, 1'b0},   // R5 no carry
        {3'd5, 4'h7, 4'h1, 4'h8, 1'b1},   // R6 positive overflow
        {3'd5, 4'h8, 4'hF, 4'h7, 1'b1},   // R6 negative overflow
        {3'd5, 4'hF, 4'hF, 4'hE, 1'b0},   // R6
        {3'd6, 4'h4, 4'h7, 4'hD, 1'b0},   // R7
        {3'd6, 4'h0, 4'h8, 4'h8, 1'b1},   // R7 minus most negative
        {3'd6, 4'h8, 4'h1, 4'h7, 1'b1},   // R7
        {3'd7, 4'h7, 4'h8, 4'h1, 1'b1},   // R8
        {3'd7, 4'h3, 4'h3, 4'h0, 1'b0}    // R8
    };

    function automatic string req_of(input int code);
        case (code)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    // drive on the falling edge, sample two ns later
    task automatic apply(input int code, input int ai, input int bi,
                         input int ex, input int ev);
        @(negedge clk);
        op = 3'(code);
        a  = W'(ai);
        b  = W'(bi);
        #2;
        checks++;
        if (x !== W'(ex) || v !== 1'(ev)) begin
            errors++;
            $display("FAIL %s op=%0d a=%0h b=%0h: got x=%0h v=%0b, expected x=%0h v=%0b",
                     req_of(code), code, ai, bi, x, v, ex, ev);
        end
    endtask

    initial begin
        op = 3'd0; a = '0; b = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // start-of-run state: pass-through of zero (R1)
        apply(0, 0, 0, 0, 0);

        for (int k = 0; k < NV; k++) begin
            apply(int'(VEC[k][15:13]), int'(VEC[k][12:9]), int'(VEC[k][8:5]),
                  int'(VEC[k][4:1]), int'(VEC[k][0]));
        end

        // full sweep against the integer reference
        for (int c = 0; c < 8; c++) begin
            for (int ai = 0; ai < 16; ai++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    int sa, sb, s, ex, ev;
                    sa = (ai >= 8) ? ai - 16 : ai;
                    sb = (bi >= 8) ? bi - 16 : bi;
                    case (c)
                        0: begin ex = ai; ev = 0; end
                        1: begin ex = bi; ev = 0; end
                        2: begin ex = (-ai) & 15; ev = (ai == 8) ? 1 : 0; end
                        3: begin ex = (-bi) & 15; ev = (bi == 8) ? 1 : 0; end
                        4: begin ex = (ai + bi) & 15; ev = (ai + bi > 15) ? 1 : 0; end
                        5: begin s = sa + sb; ex = s & 15; ev = (s > 7 || s < -8) ? 1 : 0; end
                        6: begin s = sa - sb; ex = s & 15; ev = (s > 7 || s < -8) ? 1 : 0; end
                        default: begin s = sb - sa; ex = s & 15; ev = (s > 7 || s < -8) ? 1 : 0; end
                    endcase
                    apply(c, ai, bi, ex, ev);
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule